// File: doc/BRIEF.md
# Dual-Protocol Host Register Port

This block is the slave side of a small host-facing register bank. A static style input picks which of two parallel bus conventions the host uses. In the latch style, a latch-enable pin captures the address and separate active-low read and write strobes start the transfer. In the strobe style, the same pin serves as an active-low address strobe, and a read/write level together with an active-low data strobe starts the transfer. The two styles share one register file, one address holding register and one completion output whose active level flips with the style.

Every host control pin goes through a two-stage synchronizer into the block clock before any edge is detected. The handshake output is paired with an enable that is low whenever chip select is inactive, so the pad tristate sits outside the block. A set of sticky alarm status bits, gated by per-bit masks, drives a registered active-high interrupt.

The register map is fixed. Offset 0 holds status A and offset 1 holds status B; both are read-only and clear when read. Offset 2 holds mask A and offset 3 holds mask B. Offsets 4 to 7 are general read/write registers. Every other offset is unimplemented.

Top module: `hostbus_regif`

## Requirements
- R1: With `bus_style`=1, a falling edge on `ale_as` latches `addr`. `stb_a_n` low starts a read and `stb_b` low (with `stb_a_n` high) starts a write. `hs_val` goes high in the 4th clock after the strobe change, which is two cycles after the synchronized strobe is seen.
- R2: With `bus_style`=0, a falling edge on `ale_as` latches `addr`. `stb_a_n` low starts a transfer, which is a read if `stb_b`=1 and a write if `stb_b`=0. `hs_val` rests high while selected and goes low in the 4th clock after the strobe change.
- R3: `hs_oe` is 0 within 3 clocks after `cs_n` goes high, and stays 0 while `cs_n` is high.
- R4: While `cs_n` is high, strobes perform no read or write and produce no handshake.
- R5: After the strobe is released, `hs_val` returns to its idle level in the 3rd clock.
- R6: A bit of status A (offset 0) or status B (offset 1) is set by a one-cycle pulse on its `alarm*_in` bit. It stays set until a read of its register, and that read returns the set bits and clears them. An alarm that arrives in the same cycle as the clearing read stays set.
- R7: `irq` is 1 exactly when some status bit is set whose mask bit (offset 2 for A, offset 3 for B) is 0. It follows changes one clock later.
- R8: Reads of offsets 8 to 15 return 0, and writes to them change no register.
- R9: `rst_n` low (synchronous) clears all registers, `rdata`, `irq` and `hs_oe`.
- R10: Offsets 2 to 7 read back the last value written to them; `rdata` holds the read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_style | input | 1 | Static bus convention: 1 latch style, 0 strobe style |
| ale_as | input | 1 | Address latch enable (style 1) or address strobe (style 0); falling edge latches |
| cs_n | input | 1 | Active-low chip select |
| stb_a_n | input | 1 | Read strobe (style 1) or data strobe (style 0), active low |
| stb_b | input | 1 | Write strobe active low (style 1) or read/write level (style 0) |
| addr | input | AW | Register offset |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| alarm0_in | input | DW | Alarm event pulses for status A |
| alarm1_in | input | DW | Alarm event pulses for status B |
| hs_val | output | 1 | Completion handshake level |
| hs_oe | output | 1 | Drive enable for the handshake pad |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest case to reach from the pins is an alarm pulse that lands in the very clock edge where a status read clears its register. The bench reaches it by counting the synchronizer stages from the strobe change and driving the pulse across the third edge. It then checks that the read returned the old contents and that the next read shows the new alarm. Strobes under a deasserted chip select are also exercised, and the untouched registers are read back afterwards. A seeded random mix of both bus styles, alarm pulses and mask writes covers the rest.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  typedef enum logic {
    BUS_STROBE = 1'b0,
    BUS_LATCH  = 1'b1
  } bus_style_e;

  localparam int STAT_A_OFS = 0;
  localparam int STAT_B_OFS = 1;
  localparam int MASK_A_OFS = 2;
  localparam int MASK_B_OFS = 3;
  localparam int GP_OFS     = 4;
endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front
  import hostbus_pkg::*;
#(
  parameter int AW = 4,
  parameter int HS_DELAY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_style_e    mode,
  input  logic          ale_s,
  input  logic          cs_n_s,
  input  logic          stra_n_s,
  input  logic          strb_s,
  input  logic [AW-1:0] addr_i,
  output logic          op_rd,
  output logic          op_wr,
  output logic [AW-1:0] op_addr,
  output logic          hs_val,
  output logic          hs_oe
);
  localparam int CW = $clog2(HS_DELAY + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(HS_DELAY);
  localparam logic [CW-1:0] CNT_ARM = CW'(HS_DELAY - 1);

  logic          ale_d;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          done_q, hs_val_q, hs_oe_q;
  logic          rd_req, wr_req, sel, act, done_nxt, fire;

  always_comb begin
    if (mode == BUS_LATCH) begin
      rd_req = ~stra_n_s;
      wr_req = ~strb_s & stra_n_s;
    end else begin
      rd_req = ~stra_n_s & strb_s;
      wr_req = ~stra_n_s & ~strb_s;
    end
  end

  assign sel      = ~cs_n_s;
  assign act      = sel & (rd_req | wr_req);
  assign done_nxt = act & (cnt_q >= CNT_ARM);
  assign fire     = act & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_d    <= 1'b1;
      addr_q   <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      hs_val_q <= 1'b0;
      hs_oe_q  <= 1'b0;
    end else begin
      ale_d <= ale_s;
      if (ale_d && !ale_s) addr_q <= addr_i;
      if (!act) cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      done_q   <= done_nxt;
      hs_val_q <= (mode == BUS_LATCH) ? done_nxt : ~done_nxt;
      hs_oe_q  <= sel;
    end
  end

  assign op_rd   = fire & rd_req;
  assign op_wr   = fire & wr_req;
  assign op_addr = addr_q;
  assign hs_val  = hs_val_q;
  assign hs_oe   = hs_oe_q;

  // R1/R2: completion only after the request has been held for consecutive cycles
  assert_hs_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> act && $past(act));

  // R5: dropping the request always clears completion on the next edge
  assert_hs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !done_q);
endmodule

// File: rtl/hostbus_regfile.sv
module hostbus_regfile
  import hostbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int NGP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_rd,
  input  logic          op_wr,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] alarm0,
  input  logic [DW-1:0] alarm1,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_S0 = AW'(STAT_A_OFS);
  localparam logic [AW-1:0] A_S1 = AW'(STAT_B_OFS);
  localparam logic [AW-1:0] A_M0 = AW'(MASK_A_OFS);
  localparam logic [AW-1:0] A_M1 = AW'(MASK_B_OFS);

  logic [DW-1:0] s0_q, s1_q, m0_q, m1_q, rdata_q, rd_mux;
  logic [DW-1:0] gp_q [NGP];
  logic [NGP-1:0] gp_hit;
  logic          irq_q, hit_any, clr0, clr1;

  always_comb begin
    for (int i = 0; i < NGP; i++) gp_hit[i] = (op_addr == AW'(GP_OFS + i));
  end

  assign hit_any = (op_addr == A_S0) | (op_addr == A_S1) | (op_addr == A_M0) |
                   (op_addr == A_M1) | (|gp_hit);
  assign clr0 = op_rd & (op_addr == A_S0);
  assign clr1 = op_rd & (op_addr == A_S1);

  always_comb begin
    rd_mux = '0;
    if (op_addr == A_S0) rd_mux = s0_q;
    else if (op_addr == A_S1) rd_mux = s1_q;
    else if (op_addr == A_M0) rd_mux = m0_q;
    else if (op_addr == A_M1) rd_mux = m1_q;
    else begin
      for (int i = 0; i < NGP; i++) if (gp_hit[i]) rd_mux = gp_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_q    <= '0;
      s1_q    <= '0;
      m0_q    <= '0;
      m1_q    <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
      for (int i = 0; i < NGP; i++) gp_q[i] <= '0;
    end else begin
      s0_q <= (clr0 ? '0 : s0_q) | alarm0;
      s1_q <= (clr1 ? '0 : s1_q) | alarm1;
      if (op_wr && op_addr == A_M0) m0_q <= wdata;
      if (op_wr && op_addr == A_M1) m1_q <= wdata;
      for (int i = 0; i < NGP; i++) if (op_wr && gp_hit[i]) gp_q[i] <= wdata;
      if (op_rd) rdata_q <= rd_mux;
      irq_q <= (|(s0_q & ~m0_q)) | (|(s1_q & ~m1_q));
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  // R6: status bits never drop without a clearing read
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr0 |=> ((s0_q & $past(s0_q)) == $past(s0_q)));

  // R7: no pending status means the interrupt is low one cycle later
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_q == '0 && s1_q == '0) |=> !irq_q);

  // R8: a write to a hole leaves the masks untouched
  assert_unimpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && !hit_any) |=> ($stable(m0_q) && $stable(m1_q)));
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif
  import hostbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int NGP = 4,
  parameter int HS_DELAY = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_style,
  input  logic          ale_as,
  input  logic          cs_n,
  input  logic          stb_a_n,
  input  logic          stb_b,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] alarm0_in,
  input  logic [DW-1:0] alarm1_in,
  output logic          hs_val,
  output logic          hs_oe,
  output logic          irq
);
  localparam int NCTL = 4;

  logic [NCTL-1:0] ctl_raw, ctl_s;
  logic            op_rd, op_wr;
  logic [AW-1:0]   op_addr;

  assign ctl_raw = {ale_as, cs_n, stb_a_n, stb_b};

  hostbus_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ctl_raw),
    .dout (ctl_s)
  );

  hostbus_front #(.AW(AW), .HS_DELAY(HS_DELAY)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (bus_style_e'(bus_style)),
    .ale_s   (ctl_s[3]),
    .cs_n_s  (ctl_s[2]),
    .stra_n_s(ctl_s[1]),
    .strb_s  (ctl_s[0]),
    .addr_i  (addr),
    .op_rd   (op_rd),
    .op_wr   (op_wr),
    .op_addr (op_addr),
    .hs_val  (hs_val),
    .hs_oe   (hs_oe)
  );

  hostbus_regfile #(.DW(DW), .AW(AW), .NGP(NGP)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_rd  (op_rd),
    .op_wr  (op_wr),
    .op_addr(op_addr),
    .wdata  (wdata),
    .alarm0 (alarm0_in),
    .alarm1 (alarm1_in),
    .rdata  (rdata),
    .irq    (irq)
  );
endmodule

// File: tb/hostbus_regif_tb.sv
module hostbus_regif_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_style = 1'b1;
  logic ale_as = 1'b0, cs_n = 1'b1, stb_a_n = 1'b1, stb_b = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, alarm0_in = '0, alarm1_in = '0;
  logic [7:0] rdata;
  logic hs_val, hs_oe, irq;

  int checks = 0, errors = 0;
  logic [7:0] m_gp [4];
  logic [7:0] m_s0, m_s1, m_m0, m_m1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbus_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .ale_as(ale_as), .cs_n(cs_n),
    .stb_a_n(stb_a_n), .stb_b(stb_b), .addr(addr), .wdata(wdata), .rdata(rdata),
    .alarm0_in(alarm0_in), .alarm1_in(alarm1_in), .hs_val(hs_val), .hs_oe(hs_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] mdl_read(input logic [3:0] a);
    case (a)
      4'd0: return m_s0;
      4'd1: return m_s1;
      4'd2: return m_m0;
      4'd3: return m_m1;
      4'd4, 4'd5, 4'd6, 4'd7: return m_gp[a-4];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic mdl_irq();
    return (|(m_s0 & ~m_m0)) | (|(m_s1 & ~m_m1));
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < 4; i++) m_gp[i] = '0;
    m_s0 = '0; m_s1 = '0; m_m0 = '0; m_m1 = '0;
  endtask

  // One host transfer; s0_pulse is driven onto alarm0_in across the operation edge.
  task automatic access(input bit wr, input logic [3:0] a, input logic [7:0] d,
                        input logic [7:0] s0_pulse, output logic [7:0] q);
    int lat, rel;
    @(negedge clk);
    cs_n = 1'b0; addr = a; wdata = d; ale_as = 1'b1;
    repeat (2) @(negedge clk);
    ale_as = 1'b0;
    repeat (4) @(negedge clk);
    if (bus_style) begin
      if (wr) stb_b = 1'b0; else stb_a_n = 1'b0;
    end else begin
      stb_b = ~wr; stb_a_n = 1'b0;
    end
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 2) alarm0_in = s0_pulse;
      if (lat == 3) alarm0_in = '0;
    end while (!(hs_oe && hs_val == bus_style) && lat < 20);
    alarm0_in = '0;
    chk(bus_style ? "R1 handshake latency" : "R2 acknowledge latency", lat, 4);
    q = rdata;
    stb_a_n = 1'b1; stb_b = 1'b1;
    rel = 0;
    do begin
      @(negedge clk);
      rel++;
    end while (hs_val == bus_style && rel < 20);
    chk("R5 release latency", rel, 3);
    cs_n = 1'b1; ale_as = ~bus_style;
    repeat (3) @(negedge clk);
    chk("R3 enable off after deselect", hs_oe, 0);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q;
    access(1'b1, a, d, 8'h00, q);
    if (a == 4'd2) m_m0 = d;
    else if (a == 4'd3) m_m1 = d;
    else if (a >= 4'd4 && a <= 4'd7) m_gp[a-4] = d;
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    logic [7:0] q, e;
    e = mdl_read(a);
    access(1'b0, a, 8'h00, 8'h00, q);
    chk(req, q, e);
    if (a == 4'd0) m_s0 = '0;
    if (a == 4'd1) m_s1 = '0;
  endtask

  task automatic pulse_alarm(input logic [7:0] a0, input logic [7:0] a1);
    @(negedge clk);
    alarm0_in = a0; alarm1_in = a1;
    @(negedge clk);
    alarm0_in = '0; alarm1_in = '0;
    m_s0 |= a0; m_s1 |= a1;
    @(negedge clk);
    chk("R7 interrupt level", irq, mdl_irq());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    bit ok;
    void'($urandom(32'h5eed1234));
    mdl_reset();
    repeat (12) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 rdata after reset", rdata, 0);
    chk("R9 irq after reset", irq, 0);
    chk("R9 hs_oe after reset", hs_oe, 0);

    // R1 / R10: latch style write and readback
    bus_style = 1'b1; ale_as = 1'b0;
    repeat (4) @(negedge clk);
    do_write(4'd4, 8'hA5);
    do_read(4'd4, "R10 latch-style readback");
    // R2: strobe style, acknowledge rests high while selected
    bus_style = 1'b0; ale_as = 1'b1;
    repeat (4) @(negedge clk);
    do_write(4'd5, 8'h3C);
    do_read(4'd5, "R10 strobe-style readback");
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 idle acknowledge level", {hs_oe, hs_val}, 2'b11);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: strobes without chip select do nothing
    bus_style = 1'b1; ale_as = 1'b0;
    repeat (4) @(negedge clk);
    addr = 4'd4; wdata = 8'h11; ale_as = 1'b1;
    repeat (2) @(negedge clk);
    ale_as = 1'b0;
    repeat (3) @(negedge clk);
    stb_b = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (hs_oe !== 1'b0 || hs_val !== 1'b0) ok = 1'b0;
    end
    stb_b = 1'b1;
    chk("R4 no handshake when deselected", ok, 1);
    repeat (4) @(negedge clk);
    do_read(4'd4, "R4 register unchanged after deselected write");

    // R6 / R7: sticky alarms, masking, read-to-clear
    pulse_alarm(8'h81, 8'h00);
    chk("R7 irq raised by unmasked alarm", irq, 1);
    do_write(4'd2, 8'h81);
    repeat (2) @(negedge clk);
    chk("R7 irq blocked by mask", irq, 0);
    do_read(4'd0, "R6 status A returns set bits");
    do_read(4'd0, "R6 status A cleared by read");
    do_write(4'd2, 8'h00);
    pulse_alarm(8'h00, 8'h40);
    chk("R7 irq from status B", irq, 1);
    do_read(4'd1, "R6 status B read");
    repeat (2) @(negedge clk);
    chk("R7 irq drops after clear", irq, 0);
    // R6: alarm coincident with the clearing read survives
    pulse_alarm(8'h02, 8'h00);
    access(1'b0, 4'd0, 8'h00, 8'h10, q);
    chk("R6 read returns pre-collision value", q, 8'h02);
    m_s0 = 8'h10;
    do_read(4'd0, "R6 collision alarm kept");

    // R8: holes
    do_write(4'd9, 8'hFF);
    do_read(4'd9, "R8 hole reads zero");
    do_read(4'd12, "R8 hole reads zero");
    for (int i = 2; i < 8; i++) do_read(4'(i), "R8 registers untouched by hole write");

    // Random mix, both styles
    for (int n = 0; n < 160; n++) begin
      logic [3:0] a;
      if (n % 40 == 0) begin
        bus_style = ~bus_style; ale_as = ~bus_style;
        repeat (4) @(negedge clk);
      end
      a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom));
      else do_read(a, "R10 random read matches model");
      if ($urandom_range(0, 3) == 0)
        pulse_alarm(8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom));
    end

    // R9: reset in mid-run clears registers
    do_write(4'd6, 8'h77);
    do_write(4'd3, 8'h0F);
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    mdl_reset();
    bus_style = 1'b1; ale_as = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 irq cleared by reset", irq, 0);
    do_read(4'd6, "R9 general register cleared");
    do_read(4'd3, "R9 mask cleared");
    finish_run();
  end
endmodule